// File: doc/BRIEF.md
# Multi-Slot Fixed-Latency Issue and Writeback Core

This block is the execution heart of a statically scheduled wide-issue machine. Every clock that the stall input is low, it takes one instruction word that holds one operation per issue slot. Each operation reads two operands from a shared register file through the slot's own read ports, as the registers stand at that moment. It then writes one result back through the slot's own write port after a latency that depends only on its opcode. No hazard detection exists: getting the order right is the scheduler's job. The core only reports the one case that it cannot honour, which is two results of one slot that are due on the same write port at the same edge.

A stall freezes everything. No word is taken, no result moves and no register is written. When the stall is released, the in-flight work carries on exactly where it stopped. A debug read port lets the surrounding logic, or a bench, read any register at any time.

Top module: `vliw_core`

## Requirements
- R1: A synchronous reset sets all 16 registers to zero, empties every in-flight result and clears the conflict flag.
- R2: Word layout: slot s uses bits [15s+14:15s], with opcode [14:12], destination [11:8], source A [7:4] and source B [3:0]. Opcode 1 (A+B), opcode 2 (A xor B) and opcode 5 (load the 8-bit value {A-index,B-index}, zero-extended) take 1 cycle. The result is visible on the debug port right after the edge that accepts the word.
- R3: Opcode 3 writes the low 32 bits of A*B. The destination still holds its old value after the accepting edge and holds the product after the next unstalled edge.
- R4: Opcode 4 writes (A << B[2:0]) + B, visible after the second unstalled edge following the accepting edge.
- R5: No interlock: operands are read as the registers stand at acceptance, even when an older operation to that register is still in flight.
- R6: With stall low, a new word is accepted every cycle, whatever multi-cycle operations are pending.
- R7: Opcodes 0, 6 and 7 write nothing and never set the conflict flag.
- R8: While stall is high, the word is ignored, no register is written and in-flight results keep their remaining latency. They resume unchanged after release.
- R9: If an accepted operation would reach its slot's write port at the same edge as an older result of that slot, the older result is written, the younger is dropped, and the conflict flag goes high from the accepting edge on.
- R10: Once set, the conflict flag stays high until reset.
- R11: If both slots write the same register at the same edge, slot 1's value is kept and the conflict flag is not touched.
- R12: A result still in flight when reset is applied never reaches the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze issue and all in-flight results |
| instr_word | input | 30 | One operation per slot, slot 0 in the low bits |
| dbg_addr | input | 4 | Register index for the debug read |
| dbg_data | output | 32 | Current content of the addressed register |
| conflict_err | output | 1 | Sticky same-slot write-port collision flag |

## Verification
Two things can fall on the same edge. One is the retirement of an older multi-cycle result and that of a younger, shorter one in the same slot, which is a collision. The other is two slots writing one register, which is not. The bench provokes the first with back-to-back multiply-then-add and shift-add-then-multiply pairs in one slot. It provokes the second with a multiply in slot 0 followed by a load in slot 1 to the same destination, and with a long random stream that has stalls mixed in. A behavioural model keyed by absolute due cycle judges both cases on every clock, through the debug port and the flag.

// File: rtl/vliw_pkg.sv
package vliw_pkg;

  localparam int DATA_W  = 32;
  localparam int OPC_W   = 3;
  localparam int MAX_LAT = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 3'd0,
    OP_ADD   = 3'd1,
    OP_XOR   = 3'd2,
    OP_MULLO = 3'd3,
    OP_SHADD = 3'd4,
    OP_LDI   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } opc_e;

  // Fixed cycles from acceptance to writeback; 0 means no writeback.
  function automatic int op_latency(input logic [OPC_W-1:0] opc);
    case (opc)
      OP_ADD, OP_XOR, OP_LDI: return 1;
      OP_MULLO:               return 2;
      OP_SHADD:               return 3;
      default:                return 0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] op_exec(
    input logic [OPC_W-1:0]  opc,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] imm
  );
    case (opc)
      OP_ADD:   return a + b;
      OP_XOR:   return a ^ b;
      OP_MULLO: return a * b;
      OP_SHADD: return (a << b[2:0]) + b;
      OP_LDI:   return imm;
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/vliw_regfile.sv
module vliw_regfile
  import vliw_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int NUM_WR    = 2,
  parameter int NUM_RD    = 5,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_WR-1:0]              we,
  input  logic [NUM_WR-1:0][IDX_W-1:0]   waddr,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wdata,
  input  logic [NUM_RD-1:0][IDX_W-1:0]   raddr,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata
);

  logic [DATA_W-1:0] mem [REG_COUNT];

  // Ports are applied in ascending order, so the highest slot wins a tie.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) mem[i] <= '0;
    end else begin
      for (int p = 0; p < NUM_WR; p++) begin
        if (we[p]) mem[waddr[p]] <= wdata[p];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_RD; k++) rdata[k] = mem[raddr[k]];
  end

endmodule

// File: rtl/vliw_slot_pipe.sv
module vliw_slot_pipe
  import vliw_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int DEPTH = MAX_LAT - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic [OPC_W-1:0]  issue_opc,
  input  logic [IDX_W-1:0]  issue_rd,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] imm,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              collide
);

  // Entry j retires at the (j+1)-th unstalled edge from now.
  logic [DEPTH-1:0] pend_v;
  logic [IDX_W-1:0]  pend_rd  [DEPTH];
  logic [DATA_W-1:0] pend_val [DEPTH];

  int                lat;
  logic              fresh;
  logic              keep_fresh;
  logic [DATA_W-1:0] fresh_val;

  assign lat       = op_latency(issue_opc);
  assign fresh     = !stall && (lat != 0);
  assign fresh_val = op_exec(issue_opc, opnd_a, opnd_b, imm);

  // A new op with latency L lands where entry L-1 would have retired.
  always_comb begin
    collide = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (fresh && lat == j + 1 && pend_v[j]) collide = 1'b1;
    end
  end

  assign keep_fresh = fresh && !collide;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = pend_rd[0];
    wr_data = pend_val[0];
    if (!stall) begin
      if (pend_v[0]) begin
        wr_en = 1'b1;
      end else if (keep_fresh && lat == 1) begin
        wr_en   = 1'b1;
        wr_addr = issue_rd;
        wr_data = fresh_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= '0;
    end else if (!stall) begin
      pend_v <= {1'b0, pend_v[DEPTH-1:1]};
      for (int j = 0; j < DEPTH - 1; j++) begin
        pend_rd[j]  <= pend_rd[j+1];
        pend_val[j] <= pend_val[j+1];
      end
      for (int j = 0; j < DEPTH; j++) begin
        if (keep_fresh && lat == j + 2) begin
          pend_v[j]   <= 1'b1;
          pend_rd[j]  <= issue_rd;
          pend_val[j] <= fresh_val;
        end
      end
    end
  end

endmodule

// File: rtl/vliw_core.sv
module vliw_core
  import vliw_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int REG_COUNT = 16,
  localparam int IDX_W  = $clog2(REG_COUNT),
  localparam int SLOT_W = OPC_W + 3 * IDX_W,
  localparam int WORD_W = NUM_SLOTS * SLOT_W,
  localparam int NUM_RD = 2 * NUM_SLOTS + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic [WORD_W-1:0] instr_word,
  input  logic [IDX_W-1:0]  dbg_addr,
  output logic [DATA_W-1:0] dbg_data,
  output logic              conflict_err
);

  logic [NUM_RD-1:0][IDX_W-1:0]     rd_addr;
  logic [NUM_RD-1:0][DATA_W-1:0]    rd_data;
  logic [NUM_SLOTS-1:0]             slot_wr_en;
  logic [NUM_SLOTS-1:0][IDX_W-1:0]  slot_wr_addr;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_wr_data;
  logic [NUM_SLOTS-1:0]             slot_collide;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [SLOT_W-1:0] field;
    logic [OPC_W-1:0]  opc;
    logic [IDX_W-1:0]  dst, src_a, src_b;

    assign field = instr_word[s*SLOT_W +: SLOT_W];
    assign opc   = field[SLOT_W-1 -: OPC_W];
    assign dst   = field[3*IDX_W-1 -: IDX_W];
    assign src_a = field[2*IDX_W-1 -: IDX_W];
    assign src_b = field[IDX_W-1:0];

    assign rd_addr[2*s]   = src_a;
    assign rd_addr[2*s+1] = src_b;

    vliw_slot_pipe #(.IDX_W(IDX_W)) u_pipe (
      .clk       (clk),
      .rst       (rst),
      .stall     (stall),
      .issue_opc (opc),
      .issue_rd  (dst),
      .opnd_a    (rd_data[2*s]),
      .opnd_b    (rd_data[2*s+1]),
      .imm       (DATA_W'({src_a, src_b})),
      .wr_en     (slot_wr_en[s]),
      .wr_addr   (slot_wr_addr[s]),
      .wr_data   (slot_wr_data[s]),
      .collide   (slot_collide[s])
    );
  end

  assign rd_addr[NUM_RD-1] = dbg_addr;
  assign dbg_data          = rd_data[NUM_RD-1];

  vliw_regfile #(
    .REG_COUNT (REG_COUNT),
    .NUM_WR    (NUM_SLOTS),
    .NUM_RD    (NUM_RD)
  ) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (slot_wr_en),
    .waddr (slot_wr_addr),
    .wdata (slot_wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)               conflict_err <= 1'b0;
    else if (|slot_collide) conflict_err <= 1'b1;
  end

endmodule

// File: rtl/vliw_core_chk.sv
module vliw_core_chk #(
  parameter int NUM_SLOTS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 stall,
  input logic [NUM_SLOTS-1:0] wr_en,
  input logic [NUM_SLOTS-1:0] collide,
  input logic                 conflict_err
);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    conflict_err |=> conflict_err);

  // R9
  collide_raises_err_chk: assert property (@(posedge clk) disable iff (rst)
    (|collide) |=> conflict_err);

  // R9
  err_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(conflict_err) |-> $past(|collide));

  // R8
  stall_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> !(|wr_en));

  // R8
  stall_no_collide_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> !(|collide));

endmodule

bind vliw_core vliw_core_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stall        (stall),
  .wr_en        (slot_wr_en),
  .collide      (slot_collide),
  .conflict_err (conflict_err)
);

// File: tb/vliw_core_tb.sv
`timescale 1ns/1ps
module vliw_core_tb;

  localparam int SW = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [29:0] instr_word = '0;
  logic [3:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  logic        conflict_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vliw_core u_dut (
    .clk(clk), .rst(rst), .stall(stall), .instr_word(instr_word),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .conflict_err(conflict_err)
  );

  // Behavioural model: results parked by the absolute cycle they are due.
  logic [31:0] mrf [16];
  bit          merr;
  bit          pv   [2][4];
  logic [3:0]  prd  [2][4];
  logic [31:0] pval [2][4];
  int          tick = 0;
  int          sweep = 0;

  function automatic int mlat(input logic [2:0] o);
    if (o == 3'd1 || o == 3'd2 || o == 3'd5) return 1;
    if (o == 3'd3) return 2;
    if (o == 3'd4) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] mcalc(input logic [2:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [7:0] im);
    logic [63:0] wide;
    wide = {32'd0, a} * {32'd0, b};
    if (o == 3'd1) return a + b;
    if (o == 3'd2) return a ^ b;
    if (o == 3'd3) return wide[31:0];
    if (o == 3'd4) return (a * (32'd1 << b[2:0])) + b;
    return {24'd0, im};
  endfunction

  function automatic logic [14:0] op(input int o, input int d, input int a, input int b);
    return {o[2:0], d[3:0], a[3:0], b[3:0]};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic [14:0] s0, input logic [14:0] s1,
                            input bit st, input bit rs);
    if (rs) begin
      for (int i = 0; i < 16; i++) mrf[i] = '0;
      for (int s = 0; s < 2; s++) for (int k = 0; k < 4; k++) pv[s][k] = 0;
      merr = 0;
    end else if (!st) begin
      for (int s = 0; s < 2; s++) begin
        logic [14:0] w;
        int L, k;
        w = (s == 0) ? s0 : s1;
        L = mlat(w[14:12]);
        if (L > 0) begin
          k = (tick + L - 1) % 4;
          if (pv[s][k]) merr = 1;
          else begin
            pv[s][k]   = 1;
            prd[s][k]  = w[11:8];
            pval[s][k] = mcalc(w[14:12], mrf[w[7:4]], mrf[w[3:0]], w[7:0]);
          end
        end
      end
      for (int s = 0; s < 2; s++) begin
        int k;
        k = tick % 4;
        if (pv[s][k]) begin
          mrf[prd[s][k]] = pval[s][k];
          pv[s][k] = 0;
        end
      end
      tick++;
    end
  endtask

  // One clock: drive at the falling edge, model at the rising edge, compare at the next fall.
  task automatic cyc(input logic [14:0] s0, input logic [14:0] s1, input bit st,
                     input bit rs, input int addr, input string tag);
    logic [3:0] a;
    a = (addr < 0) ? sweep[3:0] : addr[3:0];
    sweep++;
    instr_word = {s1, s0};
    stall = st;
    rst = rs;
    dbg_addr = a;
    @(posedge clk);
    model_step(s0, s1, st, rs);
    @(negedge clk);
    chk(dbg_data, mrf[a], tag);
    chk({31'd0, conflict_err}, {31'd0, merr}, {tag, " flag"});
  endtask

  task automatic run(input logic [14:0] s0, input logic [14:0] s1, input string tag);
    cyc(s0, s1, 1'b0, 1'b0, -1, tag);
  endtask

  task automatic peek(input int addr, input logic [31:0] exp, input string tag);
    cyc(15'd0, 15'd0, 1'b1, 1'b0, addr, tag);
    chk(dbg_data, exp, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    cyc(0, 0, 0, 1, -1, "R1");
    cyc(0, 0, 0, 1, -1, "R1");
    for (int i = 0; i < 16; i++) peek(i, 32'd0, "R1");
    chk({31'd0, conflict_err}, 32'd0, "R1");

    run(op(5, 1, 0, 5), op(5, 2, 0, 3), "R2");
    run(op(5, 3, 4'hA, 4'hB), op(5, 4, 1, 1), "R2");
    run(op(1, 5, 1, 2), op(2, 6, 3, 4), "R2");
    peek(5, 32'd8, "R2");
    peek(6, 32'hBA, "R2");

    run(op(3, 7, 1, 3), 0, "R3");
    peek(7, 32'd0, "R3");
    run(0, 0, "R3");
    peek(7, 32'h357, "R3");

    run(0, op(4, 8, 3, 2), "R4");
    peek(8, 32'd0, "R4");
    run(0, 0, "R4");
    peek(8, 32'd0, "R4");
    run(0, 0, "R4");
    peek(8, 32'h55B, "R4");

    run(op(3, 9, 1, 2), 0, "R5");
    run(0, op(1, 10, 9, 1), "R5");
    run(0, 0, "R5");
    peek(10, 32'd5, "R5");
    peek(9, 32'd15, "R5");

    run(op(1, 11, 11, 1), op(3, 12, 1, 1), "R6");
    run(op(1, 11, 11, 1), op(3, 12, 2, 2), "R6");
    run(op(1, 11, 11, 1), op(3, 12, 3, 1), "R6");
    run(0, 0, "R6");
    peek(11, 32'd15, "R6");
    peek(12, 32'h357, "R6");

    run(op(0, 1, 2, 2), op(6, 2, 1, 1), "R7");
    run(op(7, 3, 1, 1), op(0, 4, 0, 0), "R7");
    peek(1, 32'd5, "R7");
    peek(2, 32'd3, "R7");
    peek(3, 32'hAB, "R7");
    chk({31'd0, conflict_err}, 32'd0, "R7");

    run(op(4, 13, 1, 2), 0, "R8");
    for (int i = 0; i < 3; i++) cyc(op(5, 13, 15, 15), op(5, 14, 7, 7), 1, 0, 13, "R8");
    chk(dbg_data, 32'd0, "R8");
    run(0, 0, "R8");
    peek(13, 32'd0, "R8");
    run(0, 0, "R8");
    peek(13, 32'd43, "R8");
    peek(14, 32'd0, "R8");

    run(op(5, 15, 1, 2), op(5, 15, 3, 4), "R11");
    peek(15, 32'h34, "R11");
    run(op(3, 15, 1, 1), 0, "R11");
    run(0, op(5, 15, 5, 6), "R11");
    peek(15, 32'h56, "R11");
    chk({31'd0, conflict_err}, 32'd0, "R11");

    run(op(3, 6, 1, 2), 0, "R9");
    run(op(1, 5, 1, 1), 0, "R9");
    chk({31'd0, conflict_err}, 32'd1, "R9");
    peek(6, 32'd15, "R9");
    peek(5, 32'd8, "R9");
    run(op(4, 7, 1, 1), 0, "R9");
    run(op(3, 8, 2, 2), 0, "R9");
    run(0, 0, "R9");
    run(0, 0, "R9");
    peek(7, 32'd165, "R9");
    peek(8, 32'h55B, "R9");

    for (int i = 0; i < 4; i++) run(0, 0, "R10");
    chk({31'd0, conflict_err}, 32'd1, "R10");

    run(op(3, 14, 1, 1), op(4, 13, 1, 1), "R12");
    cyc(0, 0, 0, 1, -1, "R12");
    run(0, 0, "R12");
    run(0, 0, "R12");
    peek(14, 32'd0, "R12");
    peek(13, 32'd0, "R12");
    chk({31'd0, conflict_err}, 32'd0, "R12");

    for (int i = 0; i < 8; i++) run(op(5, i, i, 3), op(5, i + 8, 2, i), "R6");
    for (int i = 0; i < 400; i++) begin
      logic [14:0] r0, r1;
      bit st;
      r0 = 15'($urandom);
      r1 = 15'($urandom);
      st = ($urandom % 8) == 0;
      cyc(r0, r1, st, 1'b0, -1, "R9 R11 random");
    end
    for (int i = 0; i < 16; i++) peek(i, mrf[i], "R5 final");

    done = 1;
    finish_run();
  end

endmodule